// File: doc/BRIEF.md
# Packet-Aware Receive FIFO with Availability Flag

This block is a single-clock receive buffer. Each stored word carries a data payload and an end-of-packet marker. A downstream reader watches one registered flag, `avail`, to decide when to start pulling words out. By default the flag follows the fill level against a programmable threshold. When packet mode is enabled, the flag is also held high while any packet tail sits in the buffer. A reader can therefore drain short packets that would never reach the threshold.

The read side is first-word-fall-through. While `empty` is low, `rd_data` and `rd_eop` show the oldest word. Pulsing `rd_en` removes that word at the next clock edge. A system with a high-priority stream and a regular stream uses two instances, each with its own threshold and mode input. Writes into a full buffer are dropped, and reads from an empty buffer do nothing. Each of these events sets its own sticky error flag.

Top module: `rx_avail_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, the buffer and the end-of-packet count are cleared. After that edge, `empty` is 1 and `avail`, `overflow` and `underflow` are 0.
- R2: Words leave in the order they were accepted. While `empty` is 0, `rd_data` and `rd_eop` present the oldest stored word, and `rd_en` removes it at the next edge.
- R3: A write with `wr_valid` high while the buffer holds DEPTH words is discarded and leaves the contents unchanged. It sets `overflow`, which stays 1 until reset.
- R4: A read with `rd_en` high while `empty` is 1 removes nothing. It sets `underflow`, which stays 1 until reset.
- R5: With `eop_mode` at 0, `avail` in the cycle after an edge is 1 exactly when the fill level after that edge is strictly greater than the `thresh` value sampled at that edge.
- R6: With `eop_mode` at 1, `avail` is additionally 1 after any edge that leaves at least one stored word with its end-of-packet marker set, whatever the fill level.
- R7: In packet mode, a flag raised by a buffered end-of-packet stays 1 until that word has been read out. A write carrying end-of-packet and a read returning end-of-packet in the same cycle leave the tail count unchanged.
- R8: `thresh` accepts every value from 0 to DEPTH. A threshold of 0 raises `avail` one cycle after the first stored word. A threshold of DEPTH never raises it in level mode.
- R9: `empty` is 1 exactly when the fill level is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write payload |
| wr_eop | input | 1 | Marks the written word as a packet tail |
| rd_en | input | 1 | Remove the oldest word |
| rd_data | output | DATA_W | Payload of the oldest word |
| rd_eop | output | 1 | Tail marker of the oldest word |
| empty | output | 1 | Buffer holds no words |
| thresh | input | $clog2(DEPTH)+1 | Fill threshold in words |
| eop_mode | input | 1 | Enable packet-tail based availability |
| avail | output | 1 | Registered data-available flag |
| overflow | output | 1 | Sticky: a write was dropped |
| underflow | output | 1 | Sticky: a read found nothing |

## Verification
A wrong fill count appears first in `avail`, one cycle after the edge where the count goes wrong, once the level crosses the threshold. If the threshold hides it, the error still appears as an early or late `empty` within DEPTH reads. A drifting tail count stays hidden in level mode. In packet mode it shows as `avail` staying high after the last tail has left, or dropping while a tail is still stored, at the next edge. Pointer faults show as wrong `rd_data` on the very next read, and the bench compares every port on every cycle against a queue model.

// File: rtl/rx_avail_fifo.sv
module rx_avail_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_eop,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_eop,
  output logic              empty,
  input  logic [CW-1:0]     thresh,
  input  logic              eop_mode,
  output logic              avail,
  output logic              overflow,
  output logic              underflow
);

  logic [DATA_W:0] mem [DEPTH];
  logic [AW-1:0]   wptr, rptr;
  logic [CW-1:0]   fill, fill_n;
  logic [CW-1:0]   tails, tails_n;
  logic            full, wr_ok, rd_ok, tail_in, tail_out;

  assign full     = (fill == CW'(DEPTH));
  assign empty    = (fill == '0);
  assign wr_ok    = wr_valid && !full;
  assign rd_ok    = rd_en && !empty;
  assign rd_data  = mem[rptr][DATA_W-1:0];
  assign rd_eop   = mem[rptr][DATA_W];
  assign tail_in  = wr_ok && wr_eop;
  assign tail_out = rd_ok && rd_eop;

  always_comb begin
    fill_n = fill;
    if (wr_ok && !rd_ok) fill_n = fill + 1'b1;
    if (rd_ok && !wr_ok) fill_n = fill - 1'b1;
    tails_n = tails;
    if (tail_in && !tail_out) tails_n = tails + 1'b1;
    if (tail_out && !tail_in) tails_n = tails - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= {wr_eop, wr_data};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr      <= '0;
      rptr      <= '0;
      fill      <= '0;
      tails     <= '0;
      avail     <= 1'b0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) rptr <= rptr + 1'b1;
      fill      <= fill_n;
      tails     <= tails_n;
      avail     <= (fill_n > thresh) || (eop_mode && tails_n != '0);
      overflow  <= overflow  || (wr_valid && full);
      underflow <= underflow || (rd_en && empty);
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (empty && !avail && !overflow && !underflow));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (full && wr_valid && !rd_en) |=> (full && overflow && $stable(wptr)));

  assert_sticky_ovf_R3: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (empty && rd_en && !wr_valid) |=> (empty && underflow && $stable(rptr)));

  assert_sticky_unf_R4: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);

  assert_level_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(!eop_mode) && !$past(rst)) |-> (avail == (fill > $past(thresh))));

  assert_tail_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(eop_mode) && !$past(rst) && tails != '0) |-> avail);

  assert_tail_pair_R7: assert property (@(posedge clk) disable iff (rst)
    (tail_in && tail_out) |=> $stable(tails));

  assert_tail_bound_R7: assert property (@(posedge clk) disable iff (rst)
    tails <= fill);

endmodule

// File: tb/rx_avail_fifo_tb.sv
`timescale 1ns/1ps
module rx_avail_fifo_tb;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 16;
  localparam int CW     = $clog2(DEPTH) + 1;

  logic clk = 0, rst = 1;
  logic wr_valid = 0, wr_eop = 0, rd_en = 0, eop_mode = 0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [CW-1:0] thresh = '0;
  logic [DATA_W-1:0] rd_data;
  logic rd_eop, empty, avail, overflow, underflow;

  always #2.5 clk = ~clk;

  rx_avail_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data), .wr_eop(wr_eop),
    .rd_en(rd_en), .rd_data(rd_data), .rd_eop(rd_eop), .empty(empty),
    .thresh(thresh), .eop_mode(eop_mode), .avail(avail),
    .overflow(overflow), .underflow(underflow));

  logic [DATA_W:0] q[$];
  int  m_tails = 0;
  bit  m_avail = 0, m_ovf = 0, m_unf = 0;
  int  n_cmp = 0, n_bad = 0;
  bit  done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(empty == (q.size() == 0), "R9 empty", empty, q.size() == 0);
    chk(avail == m_avail, "R5/R6/R7/R8 avail", avail, m_avail);
    chk(overflow == m_ovf, "R3 overflow", overflow, m_ovf);
    chk(underflow == m_unf, "R4 underflow", underflow, m_unf);
    if (q.size() != 0) begin
      chk(rd_data == q[0][DATA_W-1:0], "R2 rd_data", rd_data, q[0][DATA_W-1:0]);
      chk(rd_eop == q[0][DATA_W], "R2 rd_eop", rd_eop, q[0][DATA_W]);
    end
  endtask

  task automatic cyc(input bit wv, input int wd, input bit we, input bit re);
    bit wok, rok;
    wr_valid = wv; wr_data = DATA_W'(wd); wr_eop = we; rd_en = re;
    #0.5;
    compare();
    @(posedge clk);
    if (rst) begin
      q.delete(); m_tails = 0; m_avail = 0; m_ovf = 0; m_unf = 0;
    end else begin
      wok = wv && q.size() < DEPTH;
      rok = re && q.size() > 0;
      if (wv && !wok) m_ovf = 1;
      if (re && !rok) m_unf = 1;
      if (rok) begin
        if (q[0][DATA_W]) m_tails--;
        void'(q.pop_front());
      end
      if (wok) begin
        q.push_back({we, DATA_W'(wd)});
        if (we) m_tails++;
      end
      m_avail = (q.size() > int'(thresh)) || (eop_mode && m_tails > 0);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst = 1; cyc(0, 0, 0, 0); cyc(0, 0, 0, 0);
    rst = 0;
    // R1 reset state
    chk(empty && !avail && !overflow && !underflow, "R1 reset", {empty, avail, overflow, underflow}, 4'b1000);

    // R5 level mode, threshold 4
    thresh = 4; eop_mode = 0;
    for (int i = 0; i < 7; i++) cyc(1, 100 + i, 0, 0);
    for (int i = 0; i < 7; i++) cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0);

    // R8 threshold 0: one word raises avail
    thresh = 0;
    cyc(1, 7, 0, 0); cyc(0, 0, 0, 0);
    chk(avail == 1, "R8 thresh0", avail, 1);
    cyc(0, 0, 0, 1); cyc(0, 0, 0, 0);

    // R8 threshold DEPTH, R3 overflow
    thresh = CW'(DEPTH);
    for (int i = 0; i < DEPTH + 3; i++) cyc(1, 200 + i, 0, 0);
    chk(avail == 0, "R8 threshDEPTH", avail, 0);
    chk(overflow == 1, "R3 sticky", overflow, 1);
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 0, 1);
    // R4 underflow
    cyc(0, 0, 0, 1); cyc(0, 0, 0, 0);
    chk(underflow == 1, "R4 sticky", underflow, 1);

    // R1 reset clears sticky flags
    rst = 1; cyc(1, 1, 1, 0); rst = 0; cyc(0, 0, 0, 0);
    chk(!overflow && !underflow && empty, "R1 reclear", {overflow, underflow}, 0);

    // R6/R7 packet mode with high threshold
    thresh = 8; eop_mode = 1;
    cyc(1, 1, 0, 0); cyc(1, 2, 1, 0); cyc(0, 0, 0, 0);
    chk(avail == 1, "R6 tail", avail, 1);
    cyc(0, 0, 0, 1); cyc(0, 0, 0, 0);
    chk(avail == 1, "R7 hold", avail, 1);
    cyc(0, 0, 0, 1); cyc(0, 0, 0, 0);
    chk(avail == 0, "R7 release", avail, 0);
    // R7 paired tail in and out
    cyc(1, 3, 1, 0); cyc(1, 4, 1, 1); cyc(0, 0, 0, 0);
    chk(avail == 1, "R7 pair", avail, 1);
    cyc(0, 0, 0, 1); cyc(0, 0, 0, 0);
    chk(avail == 0, "R7 pair drain", avail, 0);

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      if (i % 500 == 0) begin
        thresh = CW'($urandom_range(0, DEPTH));
        eop_mode = $urandom_range(0, 1);
      end
      cyc($urandom_range(0, 99) < 55, $urandom, $urandom_range(0, 3) == 0,
          $urandom_range(0, 99) < 50);
    end
    rst = 1; cyc(0, 0, 0, 0); rst = 0; cyc(0, 0, 0, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule